// File: doc/BRIEF.md
# SDLC Transmit Underrun Frame Terminator

This block closes an SDLC frame at the bit-stream level when the host stops supplying bytes. Bytes arrive over a valid/ready stream and are serialised LSB-first onto a single line output. The line advances one bit on each cycle in which `bit_en` is high. A frame opens with a flag (`0x7E`). After that, at every byte boundary the block needs a new byte. If none is offered, that is a transmit underrun, and the block appends a 16-bit closing sequence. The closing sequence is either the externally computed CRC word or an abort followed by a flag. Which one is used depends on a programmable abort-on-underrun control.

The closing sequence raises an end-of-message status and an external/status interrupt pulse at its first bit. It raises a buffer-empty interrupt pulse after its last bit. Between frames the line carries either continuous flags or continuous ones (mark idle). Loop mode masks the abort control without altering the programmed value. A hardware reset (`rst_n`) or a channel reset (`chan_rst`) clears the control and returns the sequencer to its idle state.

Stream rules: `s_ready` is high only in a cycle where `bit_en` is high and the current byte's last bit is on the line. A byte transfers when `s_valid` and `s_ready` are both high at a rising clock edge. The sender keeps `s_valid` and `s_data` steady until the transfer. If `s_valid` is low when `s_ready` rises inside a frame, the frame is closed; there is no waiting.

Top module: `sdlc_underrun_closer`

## Requirements
- R1: With the effective abort control low, an underrun is followed on the line by `crc_word` (bit 0 first, 16 bits), then one flag `0x7E` (LSB first).
- R2: With the effective abort control high and `mark_idle` low, an underrun is followed by eight ones and then one flag, with flags continuing afterwards.
- R3: `ext_irq` is a one-cycle pulse that appears in the cycle when the first closing bit is on the line. `eom_status` becomes 1 in that same cycle and stays 1 until a cycle with `eom_clr` high.
- R4: `txbe_irq` is a one-cycle pulse in the cycle after the edge that ends the 16th closing bit.
- R5: With the effective abort control high and `mark_idle` high, every line bit after the underrun is 1.
- R6: While `loop_mode` is 1 the programmed abort control is ignored (R1 closing). Once `loop_mode` returns to 0, the value written earlier applies again without a rewrite.
- R7: `rst_n` low or `chan_rst` high clears the abort control; after either, an underrun produces the R1 closing.
- R8: After the closing sequence, the line idles with flags when `mark_idle` is 0 and with ones when it is 1.
- R9: After reset the line sends one flag. A byte offered then is preceded by one opening flag, and each byte goes out LSB first. `s_ready` is high only with `bit_en` high at a byte boundary.
- R10: While `bit_en` is low, `tx_line` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| chan_rst | input | 1 | Synchronous channel reset |
| bit_en | input | 1 | Line advances one bit when high |
| s_valid | input | 1 | Byte offered |
| s_data | input | 8 | Byte to send, LSB first |
| s_ready | output | 1 | Byte accepted at this edge if valid |
| crc_word | input | 16 | CRC to append on an R1 closing, bit 0 first |
| cfg_wr | input | 1 | Write strobe for the abort control |
| cfg_abort | input | 1 | Abort-on-underrun value written by `cfg_wr` |
| mark_idle | input | 1 | Idle with ones instead of flags |
| loop_mode | input | 1 | Masks the abort control while high |
| eom_clr | input | 1 | Write-one clear of `eom_status` |
| tx_line | output | 1 | Serial line output |
| eom_status | output | 1 | Underrun/end-of-message status |
| ext_irq | output | 1 | External/status interrupt pulse |
| txbe_irq | output | 1 | Transmit-buffer-empty interrupt pulse |

## Verification
The bench builds the block with its default 16-bit closing length and 8-bit bytes. That keeps each frame short enough to sweep frames of one to three bytes against every combination of abort control, mark idle, loop mode and a continuous or half-rate `bit_en`. These combinations bring every closing path, both idle patterns and the hold behaviour between enabled cycles within reach. Dedicated runs apply a channel reset or a hardware reset after writing the control, and leave loop mode after the write. The bench predicts each line bit and each interrupt position arithmetically from the frame length.

// File: rtl/sdlc_term_pkg.sv
package sdlc_term_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam logic [BYTE_W-1:0] FLAG_PAT = 8'h7E;
  localparam logic [BYTE_W-1:0] MARK_PAT = 8'hFF;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPEN,
    ST_DATA,
    ST_CLOSE,
    ST_TAIL
  } seq_st_e;
endpackage

// File: rtl/sdlc_urun_ctl.sv
module sdlc_urun_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic chan_rst,
  input  logic wr_en,
  input  logic wr_abort,
  input  logic loop_mode,
  output logic abort_eff
);
  logic abort_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      abort_q <= 1'b0;
    end else if (chan_rst) begin
      abort_q <= 1'b0;
    end else if (wr_en) begin
      abort_q <= wr_abort;
    end
  end

  // loop mode masks the control but keeps the programmed value
  assign abort_eff = abort_q && !loop_mode;

  // R7
  chan_rst_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chan_rst |=> !abort_q);

  // R6
  loop_keeps_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_mode && !wr_en && !chan_rst) |=> $stable(abort_q));
endmodule

// File: rtl/sdlc_bit_shifter.sv
module sdlc_bit_shifter import sdlc_term_pkg::*; #(
  parameter int unsigned SH_W  = 16,
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_clr,
  input  logic             step,
  input  logic             load,
  input  logic [SH_W-1:0]  load_val,
  input  logic [CNT_W-1:0] load_last,
  output logic             line_o,
  output logic             at_boundary
);
  localparam logic [CNT_W-1:0] RST_LAST = CNT_W'(BYTE_W - 1);

  logic [SH_W-1:0]  sh_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= SH_W'(FLAG_PAT);
      cnt_q <= RST_LAST;
    end else if (sync_clr) begin
      sh_q  <= SH_W'(FLAG_PAT);
      cnt_q <= RST_LAST;
    end else if (step) begin
      if (load) begin
        sh_q  <= load_val;
        cnt_q <= load_last;
      end else begin
        sh_q  <= {1'b1, sh_q[SH_W-1:1]};
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign line_o      = sh_q[0];
  assign at_boundary = (cnt_q == '0);

  // R10
  line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !sync_clr) |=> $stable(line_o));

  // R9
  load_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (step && at_boundary));
endmodule

// File: rtl/sdlc_close_seq.sv
module sdlc_close_seq import sdlc_term_pkg::*; #(
  parameter int unsigned CRC_W = 16,
  parameter int unsigned CNT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_clr,
  input  logic              bit_en,
  input  logic              at_boundary,
  input  logic              s_valid,
  input  logic [BYTE_W-1:0] s_data,
  input  logic [CRC_W-1:0]  crc_word,
  input  logic              abort_eff,
  input  logic              mark_idle,
  input  logic              eom_clr,
  output logic              load,
  output logic [CRC_W-1:0]  load_val,
  output logic [CNT_W-1:0]  load_last,
  output logic              s_ready,
  output logic              eom,
  output logic              ext_irq,
  output logic              txbe_irq
);
  localparam logic [CRC_W-1:0] ABORT_PAT  = {FLAG_PAT, {(CRC_W-BYTE_W){1'b1}}};
  localparam logic [CRC_W-1:0] ALL_ONES   = {CRC_W{1'b1}};
  localparam logic [CNT_W-1:0] BYTE_LAST  = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] CLOSE_LAST = CNT_W'(CRC_W - 1);

  seq_st_e           st_q, st_d;
  logic              path_abort_q;
  logic              tick;
  logic              underrun;
  logic              close_done;
  logic              in_frame;
  logic [BYTE_W-1:0] idle_pat;

  assign tick     = bit_en && at_boundary;
  assign idle_pat = mark_idle ? MARK_PAT : FLAG_PAT;

  always_comb begin
    st_d       = st_q;
    load_val   = CRC_W'(idle_pat);
    load_last  = BYTE_LAST;
    underrun   = 1'b0;
    close_done = 1'b0;
    in_frame   = 1'b0;
    unique case (st_q)
      ST_IDLE, ST_TAIL: begin
        if (s_valid) begin
          st_d     = ST_OPEN;
          load_val = CRC_W'(FLAG_PAT);
        end else begin
          st_d = ST_IDLE;
        end
      end
      ST_OPEN, ST_DATA: begin
        in_frame = 1'b1;
        if (s_valid) begin
          st_d     = ST_DATA;
          load_val = CRC_W'(s_data);
        end else begin
          underrun  = 1'b1;
          st_d      = ST_CLOSE;
          load_last = CLOSE_LAST;
          if (abort_eff) begin
            load_val = mark_idle ? ALL_ONES : ABORT_PAT;
          end else begin
            load_val = crc_word;
          end
        end
      end
      ST_CLOSE: begin
        close_done = 1'b1;
        if (path_abort_q) begin
          st_d = ST_IDLE;
        end else begin
          st_d     = ST_TAIL;
          load_val = CRC_W'(FLAG_PAT);
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  assign load    = tick;
  assign s_ready = tick && in_frame;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q         <= ST_IDLE;
      path_abort_q <= 1'b0;
      eom          <= 1'b0;
      ext_irq      <= 1'b0;
      txbe_irq     <= 1'b0;
    end else if (sync_clr) begin
      st_q         <= ST_IDLE;
      path_abort_q <= 1'b0;
      eom          <= 1'b0;
      ext_irq      <= 1'b0;
      txbe_irq     <= 1'b0;
    end else begin
      ext_irq  <= tick && underrun;
      txbe_irq <= tick && close_done;
      if (tick) begin
        st_q <= st_d;
        if (underrun) begin
          path_abort_q <= abort_eff;
        end
      end
      if (tick && underrun) begin
        eom <= 1'b1;
      end else if (eom_clr) begin
        eom <= 1'b0;
      end
    end
  end

  // R3
  ext_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n || sync_clr)
    ext_irq |=> !ext_irq);

  // R3
  eom_with_irq_chk: assert property (@(posedge clk) disable iff (!rst_n || sync_clr)
    ext_irq |-> eom);

  // R3
  eom_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || sync_clr)
    (eom && !eom_clr) |=> eom);

  // R4
  txbe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n || sync_clr)
    txbe_irq |=> !txbe_irq);
endmodule

// File: rtl/sdlc_underrun_closer.sv
module sdlc_underrun_closer import sdlc_term_pkg::*; #(
  parameter int unsigned CRC_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chan_rst,
  input  logic              bit_en,
  input  logic              s_valid,
  input  logic [BYTE_W-1:0] s_data,
  output logic              s_ready,
  input  logic [CRC_W-1:0]  crc_word,
  input  logic              cfg_wr,
  input  logic              cfg_abort,
  input  logic              mark_idle,
  input  logic              loop_mode,
  input  logic              eom_clr,
  output logic              tx_line,
  output logic              eom_status,
  output logic              ext_irq,
  output logic              txbe_irq
);
  localparam int unsigned CNT_W = $clog2(CRC_W);

  logic             abort_eff;
  logic             at_boundary;
  logic             load;
  logic [CRC_W-1:0] load_val;
  logic [CNT_W-1:0] load_last;

  sdlc_urun_ctl u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .chan_rst  (chan_rst),
    .wr_en     (cfg_wr),
    .wr_abort  (cfg_abort),
    .loop_mode (loop_mode),
    .abort_eff (abort_eff)
  );

  sdlc_close_seq #(.CRC_W(CRC_W), .CNT_W(CNT_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .sync_clr    (chan_rst),
    .bit_en      (bit_en),
    .at_boundary (at_boundary),
    .s_valid     (s_valid),
    .s_data      (s_data),
    .crc_word    (crc_word),
    .abort_eff   (abort_eff),
    .mark_idle   (mark_idle),
    .eom_clr     (eom_clr),
    .load        (load),
    .load_val    (load_val),
    .load_last   (load_last),
    .s_ready     (s_ready),
    .eom         (eom_status),
    .ext_irq     (ext_irq),
    .txbe_irq    (txbe_irq)
  );

  sdlc_bit_shifter #(.SH_W(CRC_W), .CNT_W(CNT_W)) u_shift (
    .clk         (clk),
    .rst_n       (rst_n),
    .sync_clr    (chan_rst),
    .step        (bit_en),
    .load        (load),
    .load_val    (load_val),
    .load_last   (load_last),
    .line_o      (tx_line),
    .at_boundary (at_boundary)
  );
endmodule

// File: tb/test_sdlc_underrun_closer.sv
module test_sdlc_underrun_closer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        chan_rst = 1'b0;
  logic        bit_en = 1'b0;
  logic        s_valid = 1'b0;
  logic [7:0]  s_data = '0;
  logic        s_ready;
  logic [15:0] crc_word = '0;
  logic        cfg_wr = 1'b0;
  logic        cfg_abort = 1'b0;
  logic        mark_idle = 1'b0;
  logic        loop_mode = 1'b0;
  logic        eom_clr = 1'b0;
  logic        tx_line;
  logic        eom_status;
  logic        ext_irq;
  logic        txbe_irq;

  int checks = 0;
  int errors = 0;
  int run_no = 0;
  bit exp_q[$];
  bit got_q[$];

  always #5 clk = ~clk;

  sdlc_underrun_closer i_sdlc_underrun_closer (
    .clk(clk), .rst_n(rst_n), .chan_rst(chan_rst), .bit_en(bit_en),
    .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready), .crc_word(crc_word),
    .cfg_wr(cfg_wr), .cfg_abort(cfg_abort), .mark_idle(mark_idle),
    .loop_mode(loop_mode), .eom_clr(eom_clr), .tx_line(tx_line),
    .eom_status(eom_status), .ext_irq(ext_irq), .txbe_irq(txbe_irq)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s run %0d %s: actual %0d expected %0d", tag, run_no, what, act, exp);
    end
  endtask

  function automatic logic [7:0] byte_of(int run, int k);
    return 8'((150 + k * 59 + run * 7) % 256);
  endfunction

  task automatic push_bits(input logic [15:0] v, input int w);
    for (int i = 0; i < w; i++) exp_q.push_back(v[i]);
  endtask

  // clr_mode: 0 none, 1 channel reset after write, 2 hardware reset after write
  task automatic run_frame(input int n, input bit ab, input bit mk, input bit lp,
                           input bit gap, input int clr_mode, input bit loop_exit);
    bit    ab_eff;
    int    total, cyc, idx, nb, ext_cnt, ext_at, txbe_cnt, txbe_at;
    int    rdy_bad, hold_bad, mis_main, mis_post;
    bit    hold_pend, hold_val;
    string tag;
    run_no++;
    exp_q.delete();
    got_q.delete();
    @(negedge clk);
    rst_n = 1'b0; bit_en = 1'b0; s_valid = 1'b0; cfg_wr = 1'b0; eom_clr = 1'b0;
    chan_rst = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    loop_mode = lp | loop_exit;
    mark_idle = mk;
    crc_word  = 16'(16'hC35A ^ (run_no * 16'h1111));
    cfg_wr = 1'b1; cfg_abort = ab;
    @(negedge clk);
    cfg_wr = 1'b0;
    if (clr_mode == 1) begin
      chan_rst = 1'b1;
      @(negedge clk);
      chan_rst = 1'b0;
    end else if (clr_mode == 2) begin
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
    end
    if (loop_exit) loop_mode = 1'b0;
    @(negedge clk);

    ab_eff = ab && !(lp | loop_exit) && (clr_mode == 0);
    if (loop_exit) ab_eff = ab && (clr_mode == 0);
    if (clr_mode != 0) tag = "R7";
    else if (loop_exit || lp) tag = "R6";
    else if (ab_eff && mk) tag = "R5";
    else if (ab_eff) tag = "R2";
    else tag = "R1";

    push_bits(16'h7E, 8);
    push_bits(16'h7E, 8);
    for (int k = 0; k < n; k++) push_bits(16'(byte_of(run_no, k)), 8);
    if (ab_eff) begin
      push_bits(mk ? 16'hFFFF : 16'h7EFF, 16);
      push_bits(mk ? 16'hFFFF : 16'h7E7E, 16);
    end else begin
      push_bits(crc_word, 16);
      push_bits(mk ? 16'hFF7E : 16'h7E7E, 16);
    end
    total = exp_q.size();

    cyc = 0; idx = 0; nb = 0; ext_cnt = 0; ext_at = -1; txbe_cnt = 0; txbe_at = -1;
    rdy_bad = 0; hold_bad = 0; hold_pend = 1'b0; hold_val = 1'b0;
    forever begin
      @(negedge clk);
      bit_en  = gap ? cyc[0] : 1'b1;
      s_valid = (idx < n);
      s_data  = byte_of(run_no, idx);
      #1;
      if (ext_irq) begin ext_cnt++; ext_at = nb; end
      if (txbe_irq) begin txbe_cnt++; txbe_at = nb; end
      if (s_ready && !bit_en) rdy_bad++;
      if (hold_pend) begin
        if (tx_line != hold_val) hold_bad++;
        hold_pend = 1'b0;
      end
      if (!bit_en) begin
        hold_val = tx_line;
        hold_pend = 1'b1;
      end else begin
        got_q.push_back(tx_line);
        nb++;
      end
      if (s_ready && s_valid) idx++;
      cyc++;
      if (nb == total) break;
      if (cyc > 4000) begin
        chk(1'b0, tag, "frame did not finish", cyc, total);
        break;
      end
    end
    @(negedge clk);
    bit_en = 1'b0; s_valid = 1'b0;
    #1;

    mis_main = -1; mis_post = -1;
    for (int i = 0; i < got_q.size(); i++) begin
      if (got_q[i] != exp_q[i]) begin
        if (i < 32 + 8 * n) begin
          if (mis_main < 0) mis_main = i;
        end else begin
          if (mis_post < 0) mis_post = i;
        end
      end
    end
    chk(mis_main < 0, tag, "line bit index of first mismatch, frame+closing",
        mis_main, -1);
    // R8 idle pattern after the closing sequence
    chk(mis_post < 0, "R8", "line bit index of first mismatch after closing",
        mis_post, -1);
    // R9 all bytes taken, ready only with bit_en
    chk(idx == n, "R9", "bytes accepted", idx, n);
    chk(rdy_bad == 0, "R9", "s_ready cycles without bit_en", rdy_bad, 0);
    // R3 status and interrupt at first closing bit
    chk(ext_cnt == 1, "R3", "ext_irq pulse count", ext_cnt, 1);
    chk(ext_at == 16 + 8 * n, "R3", "bits sent before ext_irq", ext_at, 16 + 8 * n);
    // R4 buffer-empty after 16 closing bits
    chk(txbe_cnt == 1, "R4", "txbe_irq pulse count", txbe_cnt, 1);
    chk(txbe_at == 32 + 8 * n, "R4", "bits sent before txbe_irq", txbe_at, 32 + 8 * n);
    if (gap) chk(hold_bad == 0, "R10", "line changes while bit_en low", hold_bad, 0);
    chk(eom_status == 1'b1, "R3", "eom_status held", eom_status, 1);
    @(negedge clk);
    eom_clr = 1'b1;
    @(negedge clk);
    eom_clr = 1'b0;
    #1;
    chk(eom_status == 1'b0, "R3", "eom_status after clear", eom_status, 0);
  endtask

  initial begin : main
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    #1;
    // R9 reset state: flag bit 0 on the line, no ready, no status
    chk(tx_line == 1'b0, "R9", "tx_line in reset", tx_line, 0);
    chk(s_ready == 1'b0, "R9", "s_ready in reset", s_ready, 0);
    chk(eom_status == 1'b0, "R3", "eom_status in reset", eom_status, 0);
    chk(ext_irq == 1'b0 && txbe_irq == 1'b0, "R4", "irqs in reset",
        {ext_irq, txbe_irq}, 0);
    for (int n = 1; n <= 3; n++)
      for (int cfg = 0; cfg < 16; cfg++)
        run_frame(n, cfg[0], cfg[1], cfg[2], cfg[3], 0, 1'b0);
    // R7 channel reset and hardware reset clear the control
    run_frame(2, 1'b1, 1'b0, 1'b0, 1'b0, 1, 1'b0);
    run_frame(1, 1'b1, 1'b1, 1'b0, 1'b1, 2, 1'b0);
    // R6 value written in loop mode applies after leaving it
    run_frame(2, 1'b1, 1'b0, 1'b0, 1'b0, 0, 1'b1);
    run_frame(3, 1'b1, 1'b1, 1'b0, 1'b1, 0, 1'b1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : watchdog
    #1_900_000;
    errors++;
    $display("FAIL watchdog: run %0d did not complete", run_no);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule